// File: doc/BRIEF.md
# Mapped-Port Register Bank

This block is the 64-entry, 16-bit register bank of a small processor with separate program and data memories. Two read ports look up any entry combinationally in the same cycle, and one write port updates a single entry on the clock edge. Most entries are plain storage. A fixed set of indices is tied to the world outside the bank. Some of these are hardwired, some return live external values, and some are stored registers whose contents are also driven out to neighbouring units.

The bank decides for each index where a read comes from: stored data, a constant zero, a live timer count or the external input bus. It also decides whether a write from the normal port may land. The output-port word, the control word, the two timer periods and the four interrupt vector addresses are driven out continuously for the timer/interrupt unit and the pins. The interrupt return address is loaded only by a dedicated capture strobe. Counting timers and the ALU sit outside this block.

Top module: `regbank_mapped`

## Requirements
- R1: While reset is asserted and after it is released, every stored entry (indices 1..59 and 63), `out_port` and `ctrl_word` read as zero until written.
- R2: Index 0 always reads as 0x0000 on both read ports, and a write to index 0 changes no entry.
- R3: A write with `wr_en`=1 to an index in 1..59 is visible on both read ports from the cycle after the clock edge. Each read port selects independently of the other.
- R4: When a read addresses the same index that is being written in that cycle, the read returns the value held before the edge. There is no bypass.
- R5: `out_port` always equals the stored entry at index 58, and `ctrl_word` always equals the stored entry at index 59.
- R6: `tmr_period` carries index 52 in bits [15:0] and index 53 in bits [31:16]. `tmr_vector` carries index 54 in [15:0] and 55 in [31:16]. `ext_vector` carries index 56 in [15:0] and 57 in [31:16].
- R7: Index 60 reads `timer1_val`, index 61 reads `timer2_val` and index 62 reads `in_port`, all live in the same cycle. Writes to 60, 61 and 62 are ignored and change no entry.
- R8: Index 63 loads `irq_pc` on a clock edge where `irq_capture`=1. A write through the normal port to index 63 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_a_idx | input | 6 | Read port A index |
| rd_a_data | output | 16 | Read port A data (combinational) |
| rd_b_idx | input | 6 | Read port B index |
| rd_b_data | output | 16 | Read port B data (combinational) |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 6 | Write index |
| wr_data | input | 16 | Write data |
| irq_capture | input | 1 | Load interrupt return address into index 63 |
| irq_pc | input | 16 | PC value to capture |
| timer1_val | input | 16 | Live count of timer 1 |
| timer2_val | input | 16 | Live count of timer 2 |
| in_port | input | 16 | External input bus |
| out_port | output | 16 | Output-port word (index 58) |
| ctrl_word | output | 16 | Control word (index 59) |
| tmr_period | output | 32 | Timer periods (indices 52, 53) |
| tmr_vector | output | 32 | Timer interrupt vectors (indices 54, 55) |
| ext_vector | output | 32 | External interrupt vectors (indices 56, 57) |

## Verification
The assertions watch every cycle for these properties: at most one entry is write-enabled, an enabled write lands with the written data, index 63 never moves except on a capture, index 0 reads zero, and the live indices follow their inputs. The bench scenarios show the rest. These are the reset contents, the old-value result of a read that collides with a write, the absence of side effects from writes to protected indices, and the bit placement of the packed export buses, since these depend on sequences and on what neighbouring entries hold.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  parameter int unsigned NUM_REGS = 64;
  parameter int unsigned DATA_W   = 16;
  localparam int unsigned IDX_W   = $clog2(NUM_REGS);

  localparam int unsigned IDX_ZERO    = 0;
  localparam int unsigned IDX_PERIOD0 = 52;
  localparam int unsigned IDX_TVEC0   = 54;
  localparam int unsigned IDX_EVEC0   = 56;
  localparam int unsigned IDX_OUTP    = 58;
  localparam int unsigned IDX_CTRL    = 59;
  localparam int unsigned IDX_TMR1    = 60;
  localparam int unsigned IDX_TMR2    = 61;
  localparam int unsigned IDX_INP     = 62;
  localparam int unsigned IDX_RETPC   = 63;

  typedef enum logic [1:0] {
    KIND_ZERO    = 2'd0,
    KIND_STORE   = 2'd1,
    KIND_LIVE    = 2'd2,
    KIND_CAPTURE = 2'd3
  } reg_kind_e;

  function automatic reg_kind_e kind_of(int unsigned idx);
    if (idx == IDX_ZERO) return KIND_ZERO;
    if (idx == IDX_TMR1 || idx == IDX_TMR2 || idx == IDX_INP) return KIND_LIVE;
    if (idx == IDX_RETPC) return KIND_CAPTURE;
    return KIND_STORE;
  endfunction
endpackage

// File: rtl/regbank_rst_sync.sv
module regbank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/regbank_wr_guard.sv
module regbank_wr_guard
  import regbank_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  output logic [NUM_REGS-1:0] we_vec
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_dec
    if (kind_of(k) == KIND_STORE) begin : g_open
      assign we_vec[k] = wr_en && (wr_idx == IDX_W'(k));
    end else begin : g_shut
      assign we_vec[k] = 1'b0;
    end
  end

  // R3: a single write port can enable at most one entry
  assert_single_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));
endmodule

// File: rtl/regbank_store.sv
module regbank_store
  import regbank_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:0]              we_vec,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic                             irq_capture,
  input  logic [DATA_W-1:0]                irq_pc,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_ent
    if (kind_of(k) == KIND_STORE) begin : g_store
      logic [DATA_W-1:0] d, q;
      always_comb d = we_vec[k] ? wr_data : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign regs[k] = q;

      assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we_vec[k] |=> (regs[k] == $past(wr_data)));
    end else if (kind_of(k) == KIND_CAPTURE) begin : g_cap
      logic [DATA_W-1:0] d, q;
      always_comb d = irq_capture ? irq_pc : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign regs[k] = q;

      assert_capture_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_capture |=> (regs[k] == $past(irq_pc)));
      assert_no_port_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(k) && !irq_capture) |=> $stable(regs[k]));
    end else begin : g_none
      assign regs[k] = '0;
    end
  end
endmodule

// File: rtl/regbank_rd_mux.sv
module regbank_rd_mux
  import regbank_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [IDX_W-1:0]                 rd_idx,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
  input  logic [DATA_W-1:0]                timer1_val,
  input  logic [DATA_W-1:0]                timer2_val,
  input  logic [DATA_W-1:0]                in_port,
  output logic [DATA_W-1:0]                rd_data
);
  always_comb begin
    unique case (rd_idx)
      IDX_W'(IDX_TMR1): rd_data = timer1_val;
      IDX_W'(IDX_TMR2): rd_data = timer2_val;
      IDX_W'(IDX_INP):  rd_data = in_port;
      default:          rd_data = regs[rd_idx];
    endcase
  end

  assert_live_timer1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == IDX_W'(IDX_TMR1)) |-> (rd_data == timer1_val));
  assert_live_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == IDX_W'(IDX_INP)) |-> (rd_data == in_port));
endmodule

// File: rtl/regbank_mapped.sv
module regbank_mapped
  import regbank_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    rd_a_idx,
  output logic [DATA_W-1:0]   rd_a_data,
  input  logic [IDX_W-1:0]    rd_b_idx,
  output logic [DATA_W-1:0]   rd_b_data,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                irq_capture,
  input  logic [DATA_W-1:0]   irq_pc,
  input  logic [DATA_W-1:0]   timer1_val,
  input  logic [DATA_W-1:0]   timer2_val,
  input  logic [DATA_W-1:0]   in_port,
  output logic [DATA_W-1:0]   out_port,
  output logic [DATA_W-1:0]   ctrl_word,
  output logic [2*DATA_W-1:0] tmr_period,
  output logic [2*DATA_W-1:0] tmr_vector,
  output logic [2*DATA_W-1:0] ext_vector
);
  logic                            rst_sync_n;
  logic [NUM_REGS-1:0]             we_vec;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  regbank_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  regbank_wr_guard u_guard (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_idx(wr_idx), .we_vec(we_vec)
  );

  regbank_store u_store (
    .clk(clk), .rst_n(rst_sync_n), .we_vec(we_vec), .wr_data(wr_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .irq_capture(irq_capture), .irq_pc(irq_pc),
    .regs(regs)
  );

  regbank_rd_mux u_rd_a (
    .clk(clk), .rst_n(rst_sync_n), .rd_idx(rd_a_idx), .regs(regs),
    .timer1_val(timer1_val), .timer2_val(timer2_val), .in_port(in_port),
    .rd_data(rd_a_data)
  );

  regbank_rd_mux u_rd_b (
    .clk(clk), .rst_n(rst_sync_n), .rd_idx(rd_b_idx), .regs(regs),
    .timer1_val(timer1_val), .timer2_val(timer2_val), .in_port(in_port),
    .rd_data(rd_b_data)
  );

  assign out_port   = regs[IDX_OUTP];
  assign ctrl_word  = regs[IDX_CTRL];
  assign tmr_period = {regs[IDX_PERIOD0+1], regs[IDX_PERIOD0]};
  assign tmr_vector = {regs[IDX_TVEC0+1],   regs[IDX_TVEC0]};
  assign ext_vector = {regs[IDX_EVEC0+1],   regs[IDX_EVEC0]};

  assert_zero_reads_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_b_idx == '0) |-> (rd_b_data == '0));
endmodule

// File: tb/regbank_mapped_tb.sv
module regbank_mapped_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [15:0] rd_a_data, rd_b_data, wr_data = '0, irq_pc = '0;
  logic        wr_en = 1'b0, irq_capture = 1'b0;
  logic [15:0] timer1_val = 16'h1111, timer2_val = 16'h2222, in_port = 16'h3333;
  logic [15:0] out_port, ctrl_word;
  logic [31:0] tmr_period, tmr_vector, ext_vector;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  regbank_mapped dut_i (
    .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .irq_capture(irq_capture), .irq_pc(irq_pc),
    .timer1_val(timer1_val), .timer2_val(timer2_val), .in_port(in_port),
    .out_port(out_port), .ctrl_word(ctrl_word), .tmr_period(tmr_period),
    .tmr_vector(tmr_vector), .ext_vector(ext_vector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(input logic [5:0] idx, input logic [15:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 16'h0101 + 16'h0A05);
  endfunction

  task automatic read_a(input logic [5:0] idx, output logic [15:0] v);
    rd_a_idx = idx; #1; v = rd_a_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int i = 1; i < 64; i++) begin
      if (i >= 60 && i <= 62) continue;
      read_a(6'(i), v);
      chk("R1 reset entry", v, 16'h0);
    end
    chk("R1 out_port reset", out_port, 16'h0);
    chk("R1 ctrl_word reset", ctrl_word, 16'h0);
  endtask

  task automatic t_fill_and_read();
    logic [15:0] v;
    for (int i = 1; i < 60; i++) write(6'(i), pat(i));
    for (int i = 1; i < 60; i++) begin
      read_a(6'(i), v);
      chk("R3 port A readback", v, pat(i));
      rd_b_idx = 6'(60 - i); #1;
      chk("R3 port B readback", rd_b_data, pat(60 - i));
    end
  endtask

  task automatic t_zero();
    logic [15:0] v;
    write(6'd0, 16'hFFFF);
    read_a(6'd0, v);
    chk("R2 index 0 after write", v, 16'h0);
    rd_b_idx = 6'd0; #1;
    chk("R2 index 0 port B", rd_b_data, 16'h0);
    read_a(6'd1, v);
    chk("R2 neighbour untouched", v, pat(1));
  endtask

  task automatic t_collide();
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd30; wr_data = 16'hBEEF;
    rd_a_idx = 6'd30; rd_b_idx = 6'd30; #1;
    chk("R4 port A old value", rd_a_data, pat(30));
    chk("R4 port B old value", rd_b_data, pat(30));
    @(negedge clk);
    wr_en = 1'b0; #1;
    chk("R3 new value next cycle", rd_a_data, 16'hBEEF);
  endtask

  task automatic t_ports();
    write(6'd58, 16'hA5C3);
    chk("R5 out_port", out_port, 16'hA5C3);
    write(6'd59, 16'h7E81);
    chk("R5 ctrl_word", ctrl_word, 16'h7E81);
    chk("R6 tmr_period", tmr_period, {pat(53), pat(52)});
    chk("R6 tmr_vector", tmr_vector, {pat(55), pat(54)});
    chk("R6 ext_vector", ext_vector, {pat(57), pat(56)});
  endtask

  task automatic t_live();
    logic [15:0] v;
    read_a(6'd60, v); chk("R7 timer1 live", v, 16'h1111);
    read_a(6'd61, v); chk("R7 timer2 live", v, 16'h2222);
    read_a(6'd62, v); chk("R7 in_port live", v, 16'h3333);
    timer1_val = 16'h4242; in_port = 16'h9999;
    read_a(6'd60, v); chk("R7 timer1 follows", v, 16'h4242);
    read_a(6'd62, v); chk("R7 in_port follows", v, 16'h9999);
    write(6'd60, 16'hDEAD); write(6'd61, 16'hDEAD); write(6'd62, 16'hDEAD);
    read_a(6'd61, v); chk("R7 timer2 after write", v, 16'h2222);
    read_a(6'd63, v); chk("R7 index 63 untouched", v, 16'h0);
    chk("R7 ctrl untouched", ctrl_word, 16'h7E81);
    for (int i = 1; i < 58; i++) begin
      read_a(6'(i), v);
      chk("R7 storage untouched", v, (i == 30) ? 16'hBEEF : pat(i));
    end
  endtask

  task automatic t_capture();
    logic [15:0] v;
    write(6'd63, 16'hCAFE);
    read_a(6'd63, v); chk("R8 port write ignored", v, 16'h0);
    @(negedge clk);
    irq_capture = 1'b1; irq_pc = 16'h0123;
    @(negedge clk);
    irq_capture = 1'b0; irq_pc = 16'hFFFF;
    read_a(6'd63, v); chk("R8 captured pc", v, 16'h0123);
    @(negedge clk);
    read_a(6'd63, v); chk("R8 holds without strobe", v, 16'h0123);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd10; wr_data = 16'h5A5A;
    irq_capture = 1'b1; irq_pc = 16'h0456;
    @(negedge clk);
    wr_en = 1'b0; irq_capture = 1'b0;
    read_a(6'd63, v); chk("R8 capture with write", v, 16'h0456);
    read_a(6'd10, v); chk("R3 write alongside capture", v, 16'h5A5A);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill_and_read();
    t_zero();
    t_collide();
    t_ports();
    t_live();
    t_capture();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule